// File: doc/BRIEF.md
# GPIO bank with interrupt control

A general-purpose I/O controller for a configurable number of pins (16 by default). Software reaches it over a 32-bit register bus. The bus has a request channel and a read-response channel, and both use a valid/ready handshake. A request transfers on a clock edge where `bus_req_valid` and `bus_req_ready` are both high. A write takes effect on that same edge. A read places its data in a one-entry response slot, which is presented on the next cycle with `bus_rsp_valid` high. The slot holds its data unchanged until `bus_rsp_ready` is seen high. While a response is waiting, the block lowers `bus_req_ready`, so no further request of either kind is accepted. Writes produce no response.

Each pin has the following state:
- a bit in each of three bank registers: output data, output enable and interrupt status;
- a private configuration word that chooses its interrupt trigger, whether it may wake the CPU, push-pull or open-drain drive, and whether it drives the register bit or a shared modulator bitstream `mod_bit`.

Every bank register has write-only set and clear aliases, so software can change single bits without a read-modify-write sequence.

Pin levels pass through a two-flop synchroniser. The block then compares each synchronised level with its previous sample to find edges. Detected events latch into the status register. `irq` is the OR of all status bits. `wakeup` signals an active level on any pin that has a level trigger and has its wake bit set.

Top module: `gpio_bank_irq`

## Requirements
- R1: A register's byte address is its word offset times four. The offsets are: 0 output data, 1 output set, 2 output clear, 3 output enable, 4 enable set, 5 enable clear, 6 input, 7 interrupt status, 8 status set, 9 status clear, and 10+n for the configuration of pin n. Any other offset reads as zero and ignores writes.
- R2: Writing the set alias of a bank register (offsets 1, 4, 8) sets each target bit where the write data holds a 1 and leaves the other bits unchanged. Reading a set alias returns zero.
- R3: Writing the clear alias of a bank register (offsets 2, 5, 9) clears each target bit where the write data holds a 1 and leaves the other bits unchanged. Reading a clear alias returns zero.
- R4: Reading offset 6 returns the pin levels in bits [15:0] once they have passed two synchroniser flops. The upper bits read as zero.
- R5: The trigger type sits in configuration bits [9:7]. The codes are: 0 disabled, 1 rising edge, 2 falling edge, 3 either edge, 4 low level, 5 high level, and 6 or 7 disabled. When an enabled condition is met, the pin's status bit is set on the third clock edge after the pin changes.
- R6: A level trigger sets its status bit again on every cycle the level persists. If a pin event and a software clear of the same bit fall on the same edge, the bit stays set.
- R7: A configuration word reads back only bit 10 (wake), bits [9:7] (trigger), bit 2 (open drain) and bit 0 (source). All other bits read as zero.
- R8: With configuration bit 2 set, the pin is open-drain. Its `pad_out` is 0, and `pad_oe` is high only when output enable is set and the selected output value is 0. With bit 2 clear, `pad_out` is the selected value and `pad_oe` is the output-enable bit.
- R9: Configuration bit 0 selects the pin's output value: 1 takes `mod_bit` and 0 takes the output data bit.
- R10: `wakeup` is high when at least one pin has configuration bit 10 set, has trigger 4 or 5, and currently shows its active level. The wake bit has no effect with any other trigger.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: While a read response is valid and not accepted, `bus_req_ready` is low and `bus_rsp_rdata` and `bus_rsp_valid` hold. A request held during that time is accepted only on the edge where the response is accepted.
- R13: After reset, every bank and configuration register is zero, and `irq`, `wakeup`, `pad_oe` and `bus_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_valid | input | 1 | Request present |
| bus_req_ready | output | 1 | Request can be taken this cycle |
| bus_req_write | input | 1 | 1 write, 0 read |
| bus_req_addr | input | ADDR_W (7) | Byte address, word offset times four |
| bus_req_wdata | input | 32 | Write data |
| bus_rsp_valid | output | 1 | Read data present |
| bus_rsp_ready | input | 1 | Consumer takes read data |
| bus_rsp_rdata | output | 32 | Read data |
| pin_in | input | N_PINS (16) | Raw pin levels |
| mod_bit | input | 1 | Shared modulator bitstream |
| pad_out | output | N_PINS (16) | Value driven toward each pad |
| pad_oe | output | N_PINS (16) | Per-pad drive enable |
| irq | output | 1 | Combined interrupt |
| wakeup | output | 1 | Level-trigger wake request |

## Verification
The bench builds the block with its defaults: 16 pins and a 7-bit byte address. This covers every configuration offset from 10 to 25, and also the unmapped offsets 26 to 31, so decode edges are exercised on both sides. A vector table drives all eight trigger codes through the same edge, level and clear-collision sequence on one pin. Directed tests then cover aliases, drive modes, wake gating and response back-pressure.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W = 32;

  // word offsets (byte address = offset * 4)
  localparam int OFS_OUT      = 0;
  localparam int OFS_OUT_SET  = 1;
  localparam int OFS_OUT_CLR  = 2;
  localparam int OFS_OE       = 3;
  localparam int OFS_OE_SET   = 4;
  localparam int OFS_OE_CLR   = 5;
  localparam int OFS_IN       = 6;
  localparam int OFS_ST       = 7;
  localparam int OFS_ST_SET   = 8;
  localparam int OFS_ST_CLR   = 9;
  localparam int OFS_CFG_BASE = 10;

  // configuration word bit positions
  localparam int CFG_SRC_BIT  = 0;
  localparam int CFG_OD_BIT   = 2;
  localparam int CFG_TRIG_LSB = 7;
  localparam int CFG_WAKE_BIT = 10;

  // trigger codes
  localparam logic [2:0] TRIG_OFF  = 3'd0;
  localparam logic [2:0] TRIG_RISE = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_BOTH = 3'd3;
  localparam logic [2:0] TRIG_LOW  = 3'd4;
  localparam logic [2:0] TRIG_HIGH = 3'd5;

  typedef struct packed {
    logic       wake;
    logic [2:0] trig;
    logic       od;
    logic       src;
  } pin_cfg_t;

  function automatic logic [BUS_W-1:0] cfg_to_word(input pin_cfg_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CFG_WAKE_BIT]                   = c.wake;
    w[CFG_TRIG_LSB+2:CFG_TRIG_LSB]    = c.trig;
    w[CFG_OD_BIT]                     = c.od;
    w[CFG_SRC_BIT]                    = c.src;
    return w;
  endfunction

endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] prev_q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  pin_cfg_t cfg,
  input  logic     lvl,
  input  logic     prev,
  input  logic     out_bit,
  input  logic     oe_bit,
  input  logic     mod_bit,
  output logic     hit,
  output logic     wake_req,
  output logic     pad_out,
  output logic     pad_oe
);

  logic rise, fall, lvl_trig, drive_val;

  always_comb begin
    rise = lvl & ~prev;
    fall = ~lvl & prev;
    case (cfg.trig)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise | fall;
      TRIG_LOW:  hit = ~lvl;
      TRIG_HIGH: hit = lvl;
      default:   hit = 1'b0;
    endcase
    lvl_trig = (cfg.trig == TRIG_LOW) || (cfg.trig == TRIG_HIGH);
    wake_req = cfg.wake & lvl_trig & hit;

    drive_val = cfg.src ? mod_bit : out_bit;
    if (cfg.od) begin
      pad_out = 1'b0;
      pad_oe  = oe_bit & ~drive_val;
    end else begin
      pad_out = drive_val;
      pad_oe  = oe_bit;
    end
  end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [BUS_W-1:0]          req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [BUS_W-1:0]          rsp_rdata,
  input  logic [N_PINS-1:0]         in_lvl,
  input  logic [N_PINS-1:0]         hw_event,
  output logic [N_PINS-1:0]         out_q,
  output logic [N_PINS-1:0]         oe_q,
  output logic [N_PINS-1:0]         status_q,
  output pin_cfg_t [N_PINS-1:0]     cfg_q
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_OUT     = IDX_W'(OFS_OUT);
  localparam logic [IDX_W-1:0] I_OUT_SET = IDX_W'(OFS_OUT_SET);
  localparam logic [IDX_W-1:0] I_OUT_CLR = IDX_W'(OFS_OUT_CLR);
  localparam logic [IDX_W-1:0] I_OE      = IDX_W'(OFS_OE);
  localparam logic [IDX_W-1:0] I_OE_SET  = IDX_W'(OFS_OE_SET);
  localparam logic [IDX_W-1:0] I_OE_CLR  = IDX_W'(OFS_OE_CLR);
  localparam logic [IDX_W-1:0] I_IN      = IDX_W'(OFS_IN);
  localparam logic [IDX_W-1:0] I_ST      = IDX_W'(OFS_ST);
  localparam logic [IDX_W-1:0] I_ST_SET  = IDX_W'(OFS_ST_SET);
  localparam logic [IDX_W-1:0] I_ST_CLR  = IDX_W'(OFS_ST_CLR);

  logic [IDX_W-1:0]  idx;
  logic [N_PINS-1:0] wbits;
  logic              acc, wr_acc, rd_acc;
  logic [N_PINS-1:0] out_n, oe_n, st_n;
  logic [BUS_W-1:0]  rd_word;
  logic              unused_bus_bits;

  assign idx       = req_addr[ADDR_W-1:2];
  assign wbits     = req_wdata[N_PINS-1:0];
  assign req_ready = ~rsp_valid | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign wr_acc    = acc & req_write;
  assign rd_acc    = acc & ~req_write;
  assign unused_bus_bits = ^{req_addr[1:0], req_wdata[BUS_W-1:N_PINS]};

  // next-state of the three bank registers
  always_comb begin
    out_n = out_q;
    oe_n  = oe_q;
    st_n  = status_q;
    if (wr_acc) begin
      case (idx)
        I_OUT:     out_n = wbits;
        I_OUT_SET: out_n = out_q | wbits;
        I_OUT_CLR: out_n = out_q & ~wbits;
        I_OE:      oe_n  = wbits;
        I_OE_SET:  oe_n  = oe_q | wbits;
        I_OE_CLR:  oe_n  = oe_q & ~wbits;
        I_ST:      st_n  = wbits;
        I_ST_SET:  st_n  = status_q | wbits;
        I_ST_CLR:  st_n  = status_q & ~wbits;
        default:   ;
      endcase
    end
    // a pin event outranks any software write in the same cycle
    st_n = st_n | hw_event;
  end

  // read multiplexer
  always_comb begin
    rd_word = '0;
    case (idx)
      I_OUT:   rd_word[N_PINS-1:0] = out_q;
      I_OE:    rd_word[N_PINS-1:0] = oe_q;
      I_IN:    rd_word[N_PINS-1:0] = in_lvl;
      I_ST:    rd_word[N_PINS-1:0] = status_q;
      default: begin
        for (int i = 0; i < N_PINS; i++) begin
          if (idx == IDX_W'(OFS_CFG_BASE + i)) rd_word = cfg_to_word(cfg_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      oe_q     <= '0;
      status_q <= '0;
      cfg_q    <= '0;
    end else begin
      out_q    <= out_n;
      oe_q     <= oe_n;
      status_q <= st_n;
      for (int i = 0; i < N_PINS; i++) begin
        if (wr_acc && idx == IDX_W'(OFS_CFG_BASE + i)) begin
          cfg_q[i].wake <= req_wdata[CFG_WAKE_BIT];
          cfg_q[i].trig <= req_wdata[CFG_TRIG_LSB+2:CFG_TRIG_LSB];
          cfg_q[i].od   <= req_wdata[CFG_OD_BIT];
          cfg_q[i].src  <= req_wdata[CFG_SRC_BIT];
        end
      end
    end
  end

  // one-entry read response slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_valid,
  output logic              bus_req_ready,
  input  logic              bus_req_write,
  input  logic [ADDR_W-1:0] bus_req_addr,
  input  logic [31:0]       bus_req_wdata,
  output logic              bus_rsp_valid,
  input  logic              bus_rsp_ready,
  output logic [31:0]       bus_rsp_rdata,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              mod_bit,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              irq,
  output logic              wakeup
);

  logic [N_PINS-1:0]     lvl_q, prev_q;
  logic [N_PINS-1:0]     out_q, oe_q, status_q;
  logic [N_PINS-1:0]     hw_event, wake_vec;
  pin_cfg_t [N_PINS-1:0] cfg_q;

  gpio_input_sync #(.W(N_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_in),
    .lvl_q  (lvl_q),
    .prev_q (prev_q)
  );

  gpio_reg_file #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (bus_req_valid),
    .req_ready (bus_req_ready),
    .req_write (bus_req_write),
    .req_addr  (bus_req_addr),
    .req_wdata (bus_req_wdata),
    .rsp_valid (bus_rsp_valid),
    .rsp_ready (bus_rsp_ready),
    .rsp_rdata (bus_rsp_rdata),
    .in_lvl    (lvl_q),
    .hw_event  (hw_event),
    .out_q     (out_q),
    .oe_q      (oe_q),
    .status_q  (status_q),
    .cfg_q     (cfg_q)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gpio_pin_cell u_cell (
      .cfg      (cfg_q[g]),
      .lvl      (lvl_q[g]),
      .prev     (prev_q[g]),
      .out_bit  (out_q[g]),
      .oe_bit   (oe_q[g]),
      .mod_bit  (mod_bit),
      .hit      (hw_event[g]),
      .wake_req (wake_vec[g]),
      .pad_out  (pad_out[g]),
      .pad_oe   (pad_oe[g])
    );
  end

  assign irq    = |status_q;
  assign wakeup = |wake_vec;

endmodule

// File: rtl/gpio_bank_irq_checker.sv
module gpio_bank_irq_checker
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-3:0] word_idx,
  input logic [N_PINS-1:0] wdata,
  input logic [N_PINS-1:0] out_q,
  input logic [N_PINS-1:0] oe_q,
  input logic [N_PINS-1:0] status_q,
  input logic [N_PINS-1:0] hw_event,
  input logic              irq,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata
);

  localparam int IW = ADDR_W - 2;

  logic wr_acc;
  assign wr_acc = req_valid && req_ready && req_write;

  // R2: set alias leaves every written 1 set in the output register
  a_r2_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && word_idx == IW'(OFS_OUT_SET) |=> (out_q & $past(wdata)) == $past(wdata));

  // R3: clear alias leaves every written 1 cleared in the enable register
  a_r3_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && word_idx == IW'(OFS_OE_CLR) |=> (oe_q & $past(wdata)) == '0);

  // R6: a pin event always lands in status, whatever software wrote
  a_r6_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_event) |=> (status_q & $past(hw_event)) == $past(hw_event));

  // R11: setting a status bit raises the interrupt line
  a_r11_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && word_idx == IW'(OFS_ST_SET) && (|wdata) |=> irq);

  // R12: an unaccepted response holds
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

endmodule

bind gpio_bank_irq gpio_bank_irq_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (bus_req_valid),
  .req_ready (bus_req_ready),
  .req_write (bus_req_write),
  .word_idx  (bus_req_addr[ADDR_W-1:2]),
  .wdata     (bus_req_wdata[N_PINS-1:0]),
  .out_q     (out_q),
  .oe_q      (oe_q),
  .status_q  (status_q),
  .hw_event  (hw_event),
  .irq       (irq),
  .rsp_valid (bus_rsp_valid),
  .rsp_ready (bus_rsp_ready),
  .rsp_rdata (bus_rsp_rdata)
);

// File: tb/gpio_bank_irq_bench.sv
module gpio_bank_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req_valid = 1'b0;
  logic        bus_req_ready;
  logic        bus_req_write = 1'b0;
  logic [6:0]  bus_req_addr = '0;
  logic [31:0] bus_req_wdata = '0;
  logic        bus_rsp_valid;
  logic        bus_rsp_ready = 1'b1;
  logic [31:0] bus_rsp_rdata;
  logic [15:0] pin_in = '0;
  logic        mod_bit = 1'b0;
  logic [15:0] pad_out, pad_oe;
  logic        irq, wakeup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_bank_irq u_gpio_bank_irq (
    .clk(clk), .rst_n(rst_n),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_ready(bus_rsp_ready), .bus_rsp_rdata(bus_rsp_rdata),
    .pin_in(pin_in), .mod_bit(mod_bit), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq(irq), .wakeup(wakeup)
  );

  function automatic logic [6:0] ba(input int off);
    return 7'(off * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_write = 1'b1;
    bus_req_addr = ba(off); bus_req_wdata = d;
    @(negedge clk);
    bus_req_valid = 1'b0; bus_req_write = 1'b0;
  endtask

  task automatic bus_read(input int off, output logic [31:0] d);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_write = 1'b0; bus_req_addr = ba(off);
    @(negedge clk);
    bus_req_valid = 1'b0;
    d = bus_rsp_rdata;
  endtask

  // {trigger[2:0], level before clear, level after clear, expected status bit}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1},
    {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1},
    {3'd3, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b1, 1'b0, 1'b1},
    {3'd6, 1'b0, 1'b1, 1'b0},
    {3'd7, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13: reset state
    chk("R13 irq", {31'd0, irq}, 32'd0);
    chk("R13 wakeup", {31'd0, wakeup}, 32'd0);
    chk("R13 pad_oe", {16'd0, pad_oe}, 32'd0);
    chk("R13 rsp_valid", {31'd0, bus_rsp_valid}, 32'd0);
    bus_read(0, rd);  chk("R13 out", rd, 32'd0);
    bus_read(3, rd);  chk("R13 oe", rd, 32'd0);
    bus_read(7, rd);  chk("R13 status", rd, 32'd0);
    bus_read(25, rd); chk("R13 cfg15", rd, 32'd0);

    // R5 R6: trigger table on pin 0
    for (int k = 0; k < NV; k++) begin
      logic [2:0] t;
      t = VEC[k][5:3];
      bus_write(10, 32'(t) << 7);
      @(negedge clk) pin_in[0] = VEC[k][2];
      repeat (4) @(posedge clk);
      bus_write(9, 32'h1);
      pin_in[0] = VEC[k][1];
      repeat (4) @(posedge clk);
      bus_read(7, rd);
      chk($sformatf("R5 R6 vector %0d status", k), {31'd0, rd[0]}, {31'd0, VEC[k][0]});
      chk($sformatf("R11 vector %0d irq", k), {31'd0, irq}, {31'd0, VEC[k][0]});
    end
    // R6: level gone, clear now sticks (pin0 type 1 steady high after last vector)
    bus_write(10, 32'h0);
    bus_write(9, 32'hFFFF);
    bus_read(7, rd); chk("R6 clear after level gone", rd, 32'd0);
    chk("R11 irq low", {31'd0, irq}, 32'd0);

    // R2 R3: aliases
    bus_write(0, 32'h00F0);
    bus_write(1, 32'h0003);
    bus_read(0, rd); chk("R2 out set", rd, 32'h00F3);
    bus_write(2, 32'h0010);
    bus_read(0, rd); chk("R3 out clear", rd, 32'h00E3);
    bus_write(3, 32'h0F00);
    bus_write(4, 32'h1000);
    bus_write(5, 32'h0100);
    bus_read(3, rd); chk("R2 R3 oe set clear", rd, 32'h1E00);
    bus_read(1, rd); chk("R2 set alias reads zero", rd, 32'd0);
    bus_read(5, rd); chk("R3 clear alias reads zero", rd, 32'd0);
    bus_write(8, 32'h8000);
    chk("R11 irq after status set", {31'd0, irq}, 32'd1);
    bus_read(7, rd); chk("R2 status set", rd, 32'h8000);
    bus_write(9, 32'h8000);
    chk("R11 irq after status clear", {31'd0, irq}, 32'd0);

    // R1: unmapped offsets
    bus_write(30, 32'hFFFF_FFFF);
    bus_read(30, rd); chk("R1 unmapped 30", rd, 32'd0);
    bus_read(26, rd); chk("R1 unmapped 26", rd, 32'd0);

    // R7: config readback mask
    bus_write(17, 32'hFFFF_FFFF);
    bus_read(17, rd); chk("R7 cfg mask", rd, 32'h0000_0785);
    bus_write(17, 32'h0);

    // R4: input register
    @(negedge clk) pin_in = 16'hA5C3;
    repeat (3) @(posedge clk);
    bus_read(6, rd); chk("R4 input", rd, 32'h0000_A5C3);
    @(negedge clk) pin_in = 16'h0000;
    repeat (3) @(posedge clk);
    bus_write(9, 32'hFFFF);

    // R8 R9: drive modes (out pins 3,4 high, all enabled)
    bus_write(3, 32'hFFFF);
    bus_write(0, 32'h0018);
    bus_write(13, 32'h4);   // pin 3 open drain
    chk("R8 od release", {31'd0, pad_oe[3]}, 32'd0);
    chk("R8 od pad_out", {31'd0, pad_out[3]}, 32'd0);
    bus_write(2, 32'h0008);
    chk("R8 od drive low", {30'd0, pad_oe[3], pad_out[3]}, 32'd2);
    chk("R8 normal pin2", {30'd0, pad_oe[2], pad_out[2]}, 32'd2);
    bus_write(14, 32'h1);   // pin 4 from modulator
    @(negedge clk) mod_bit = 1'b0;
    #1 chk("R9 mod low", {31'd0, pad_out[4]}, 32'd0);
    @(negedge clk) mod_bit = 1'b1;
    #1 chk("R9 mod high", {31'd0, pad_out[4]}, 32'd1);
    bus_write(14, 32'h0);
    @(negedge clk) mod_bit = 1'b0;
    #1 chk("R9 register source", {31'd0, pad_out[4]}, 32'd1);

    // R10: wake gating on pin 5
    @(negedge clk) pin_in[5] = 1'b1;
    repeat (4) @(posedge clk);
    bus_write(15, 32'h0000_0680);
    chk("R10 wake high level", {31'd0, wakeup}, 32'd1);
    bus_write(15, 32'h0000_0480);
    chk("R10 wake ignored for edge type", {31'd0, wakeup}, 32'd0);
    bus_write(15, 32'h0000_0280);
    chk("R10 no wake bit", {31'd0, wakeup}, 32'd0);
    bus_write(15, 32'h0000_0600);
    chk("R10 low level inactive", {31'd0, wakeup}, 32'd0);
    bus_write(15, 32'h0);

    // R12: response back-pressure
    bus_write(0, 32'h0055);
    @(negedge clk);
    bus_rsp_ready = 1'b0;
    bus_req_valid = 1'b1; bus_req_write = 1'b0; bus_req_addr = ba(0);
    @(negedge clk);
    held = bus_rsp_rdata;
    chk("R12 read data", held, 32'h0055);
    bus_req_write = 1'b1; bus_req_addr = ba(0); bus_req_wdata = 32'h1234;
    #1 chk("R12 req_ready low", {31'd0, bus_req_ready}, 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R12 rsp held", {bus_rsp_valid, bus_rsp_rdata[30:0]}, {1'b1, held[30:0]});
      chk("R12 write stalled", {16'd0, pad_out[15:8]}, 32'h0000_0000 | 32'h00);
    end
    bus_rsp_ready = 1'b1;
    @(negedge clk);
    bus_req_valid = 1'b0; bus_req_write = 1'b0;
    chk("R12 write taken with response", {24'd0, pad_out[15:8]}, 32'h12);
    chk("R12 response drained", {31'd0, bus_rsp_valid}, 32'd0);
    bus_read(0, rd); chk("R12 out after stall", rd, 32'h1234);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule